// File: doc/BRIEF.md
# USB Host Root Port Control and Status Register

This block holds the control and status fields of one USB host root port. Software reaches it over a plain register bus: an address, a write strobe, write data and combinational read data. Only one register address is decoded. Its fields drive four outputs to the port logic: a reset request, a suspend level that stops start-of-frame emission downstream, a resume drive level and a PHY suspend level.

Hardware events from the port logic act on the fields without software. A detected remote wakeup, a detected disconnect and a suspend-clear request from the interrupt logic all take the port out of suspend. A remote wakeup also starts resume drive on its own, and a disconnect stops it. The overcurrent input is synchronized. Its level is shown in a read-only field, and any edge on it is latched in a flag that software clears by writing one.

Reset timing, line signalling, frame generation and interrupt gathering belong to other blocks. Software times the port reset period itself.

Top module: `usb_port_ctrl_reg`

## Requirements
- R1: After reset every field is 0, all four outputs are low, and a read of the register address returns 0.
- R2: Bit 8 (port reset) takes the written value on a register write and drives `port_reset_o`. No hardware event ever changes it.
- R3: Bit 7 (suspend) is set by a register write with bit 7 = 1. A write with bit 7 = 0 leaves it unchanged. Its value drives `port_suspend_o`.
- R4: Bit 7 is cleared in the cycle after any of these: `wakeup_det`, `disc_det`, `susp_clr_req`, or a register write with bit 8 = 1 or bit 6 = 1. Such a clear wins over a set in the same write.
- R5: Bit 6 (resume) takes the written value on a register write and drives `resume_drive_o`.
- R6: A `wakeup_det` pulse sets bit 6 and a `disc_det` pulse clears it. A disconnect wins over a wakeup, and both win over a register write in the same cycle.
- R7: Bit 4 reads the level of `ovc_in` after a two-flop synchronizer, so it follows the input two clocks late. Writes to bit 4 are ignored.
- R8: Bit 5 (overcurrent change) is set one cycle after the synchronized level differs from its registered copy, on either edge. A write with bit 5 = 1 clears it, and a write with bit 5 = 0 has no effect.
- R9: When an overcurrent edge and a write-one-to-clear of bit 5 fall in the same cycle, bit 5 ends up set.
- R10: Bit 9 (PHY clock stop) takes the written value on a register write. `phy_suspend_o` is high only while both bit 9 and bit 7 are 1.
- R11: Bits 31:10 and 3:0 read as 0. A read of any other address returns 0, and a write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register bus address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Combinational read data |
| wakeup_det | input | 1 | Remote wakeup detected, one-cycle pulse |
| disc_det | input | 1 | Disconnect detected, one-cycle pulse |
| susp_clr_req | input | 1 | Suspend clear request from interrupt logic |
| ovc_in | input | 1 | Asynchronous overcurrent level |
| port_reset_o | output | 1 | Port reset request |
| port_suspend_o | output | 1 | Port suspended, frame emission stops |
| resume_drive_o | output | 1 | Drive resume signalling |
| phy_suspend_o | output | 1 | PHY suspend |

## Verification
Each suspend clear source is applied on its own, and then together with a set in the same write, so that a missing clear term and a wrong priority fail separately. Wakeup and disconnect are pulsed alone and together to expose the resume priority. The overcurrent input is toggled in both directions, with the write-one-to-clear placed at several offsets around the latched edge. This separates the synchronizer depth, detection on both edges and the set-over-clear rule. All-ones writes and writes to a foreign address show that reserved bits, the read-only level and unselected writes have no effect.

// File: rtl/usb_port_ctrl_reg.sv
module usb_port_ctrl_reg #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wakeup_det,
  input  logic              disc_det,
  input  logic              susp_clr_req,
  input  logic              ovc_in,
  output logic              port_reset_o,
  output logic              port_suspend_o,
  output logic              resume_drive_o,
  output logic              phy_suspend_o
);
  localparam int B_ACT  = 4;
  localparam int B_CHG  = 5;
  localparam int B_RES  = 6;
  localparam int B_SUSP = 7;
  localparam int B_RST  = 8;
  localparam int B_CSTP = 9;

  logic rst_q, susp_q, res_q, chg_q, cstp_q;
  logic ovc_s1, ovc_s2, ovc_prev;

  wire sel_wr   = wr_en && (addr == REG_ADDR);
  wire susp_clr = wakeup_det | disc_det | susp_clr_req |
                  (sel_wr & wr_data[B_RST]) | (sel_wr & wr_data[B_RES]);
  wire ovc_edge = ovc_s2 ^ ovc_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q    <= 1'b0;
      susp_q   <= 1'b0;
      res_q    <= 1'b0;
      chg_q    <= 1'b0;
      cstp_q   <= 1'b0;
      ovc_s1   <= 1'b0;
      ovc_s2   <= 1'b0;
      ovc_prev <= 1'b0;
    end else begin
      ovc_s1   <= ovc_in;
      ovc_s2   <= ovc_s1;
      ovc_prev <= ovc_s2;
      if (sel_wr) begin
        rst_q  <= wr_data[B_RST];
        cstp_q <= wr_data[B_CSTP];
      end
      if (susp_clr)                      susp_q <= 1'b0;
      else if (sel_wr && wr_data[B_SUSP]) susp_q <= 1'b1;
      if (disc_det)        res_q <= 1'b0;
      else if (wakeup_det) res_q <= 1'b1;
      else if (sel_wr)     res_q <= wr_data[B_RES];
      if (ovc_edge)                      chg_q <= 1'b1;
      else if (sel_wr && wr_data[B_CHG]) chg_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == REG_ADDR) begin
      rd_data[B_ACT]  = ovc_s2;
      rd_data[B_CHG]  = chg_q;
      rd_data[B_RES]  = res_q;
      rd_data[B_SUSP] = susp_q;
      rd_data[B_RST]  = rst_q;
      rd_data[B_CSTP] = cstp_q;
    end
  end

  assign port_reset_o   = rst_q;
  assign port_suspend_o = susp_q;
  assign resume_drive_o = res_q;
  assign phy_suspend_o  = cstp_q & susp_q;

  // R2
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_reset_o && !sel_wr) |=> port_reset_o);
  // R4
  susp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wakeup_det || disc_det || susp_clr_req) |=> !port_suspend_o);
  // R6
  disc_stops_resume_chk: assert property (@(posedge clk) disc_det |=> !resume_drive_o);
  // R6
  wake_starts_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wakeup_det && !disc_det) |=> resume_drive_o);
  // R9
  chg_edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovc_s2 != ovc_prev) |=> rd_data[B_CHG] || (addr != REG_ADDR));
  // R10
  phy_needs_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_suspend_o |-> port_suspend_o);
endmodule

// File: tb/usb_port_ctrl_reg_bench.sv
`timescale 1ns/1ps
module usb_port_ctrl_reg_bench;
  localparam logic [7:0] RA = 8'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = RA;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic wakeup_det = 1'b0, disc_det = 1'b0, susp_clr_req = 1'b0, ovc_in = 1'b0;
  logic port_reset_o, port_suspend_o, resume_drive_o, phy_suspend_o;

  int n_run = 0;
  int n_fail = 0;

  usb_port_ctrl_reg u_usb_port_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wakeup_det(wakeup_det), .disc_det(disc_det),
    .susp_clr_req(susp_clr_req), .ovc_in(ovc_in), .port_reset_o(port_reset_o),
    .port_suspend_o(port_suspend_o), .resume_drive_o(resume_drive_o),
    .phy_suspend_o(phy_suspend_o));

  always #5 clk = ~clk;

  bit m_rst, m_susp, m_res, m_chg, m_cs;
  int oq[$] = '{0, 0, 0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rst = 0; m_susp = 0; m_res = 0; m_chg = 0; m_cs = 0;
      oq = '{0, 0, 0};
    end else begin
      bit wsel, edge_seen;
      wsel = wr_en && addr == RA;
      edge_seen = (oq[1] != oq[2]);
      oq.push_front(int'(ovc_in));
      void'(oq.pop_back());
      if (wsel) begin m_rst = wr_data[8]; m_cs = wr_data[9]; end
      if (wakeup_det || disc_det || susp_clr_req || (wsel && (wr_data[8] || wr_data[6])))
        m_susp = 0;
      else if (wsel && wr_data[7]) m_susp = 1;
      if (disc_det) m_res = 0;
      else if (wakeup_det) m_res = 1;
      else if (wsel) m_res = wr_data[6];
      if (edge_seen) m_chg = 1;
      else if (wsel && wr_data[5]) m_chg = 0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (addr == RA) begin
      chk("R2 reset bit", 32'(rd_data[8]), 32'(m_rst));
      chk("R3,R4 suspend bit", 32'(rd_data[7]), 32'(m_susp));
      chk("R5,R6 resume bit", 32'(rd_data[6]), 32'(m_res));
      chk("R8,R9 change bit", 32'(rd_data[5]), 32'(m_chg));
      chk("R7 active bit", 32'(rd_data[4]), 32'(oq[1]));
      chk("R10 clock stop bit", 32'(rd_data[9]), 32'(m_cs));
      chk("R11 reserved bits", rd_data & 32'hFFFF_FC0F, 32'h0);
    end else
      chk("R11 other address read", rd_data, 32'h0);
    chk("R2 port_reset_o", 32'(port_reset_o), 32'(m_rst));
    chk("R3 port_suspend_o", 32'(port_suspend_o), 32'(m_susp));
    chk("R5 resume_drive_o", 32'(resume_drive_o), 32'(m_res));
    chk("R10 phy_suspend_o", 32'(phy_suspend_o), 32'(m_cs & m_susp));
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(logic [31:0] d, logic [7:0] a = RA);
    addr = a; wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0; addr = RA;
  endtask

  initial begin
    #150000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    chk("R1 read after reset", rd_data, 32'h0);
    chk("R1 outputs after reset",
        {28'h0, port_reset_o, port_suspend_o, resume_drive_o, phy_suspend_o}, 32'h0);
    // R2 set, hold, clear
    wr(32'h100); tick(3); wr(32'h0); tick();
    // R3 set, then a write of 0 does not clear
    wr(32'h80); tick(); wr(32'h0); tick();
    // R10 clock stop with suspend
    wr(32'h280); tick(2);
    // R4,R6 wakeup clears suspend, sets resume
    wakeup_det = 1; tick(); wakeup_det = 0; tick();
    // R5 software clears resume
    wr(32'h200); wr(32'h280);
    disc_det = 1; tick(); disc_det = 0; tick();
    wr(32'h80);
    susp_clr_req = 1; tick(); susp_clr_req = 0; tick();
    wr(32'h80); wr(32'h100); tick(); wr(32'h0);
    wr(32'h80); wr(32'h40); tick();
    // R4 clear beats set in the same write
    wr(32'hC0); tick();
    // R6 disconnect beats wakeup
    wakeup_det = 1; disc_det = 1; tick(); wakeup_det = 0; disc_det = 0; tick();
    wr(32'h40); disc_det = 1; tick(); disc_det = 0;
    // R8,R9 edges on both directions, clears at varying offsets
    for (int off = 0; off < 5; off++) begin
      ovc_in = ~ovc_in;
      tick(off);
      wr(32'h20);
      tick(4);
      wr(32'h20);
      wr(32'h0);
      tick();
    end
    // R7 write to active bit ignored
    ovc_in = 1; tick(4); wr(32'h10); tick(); wr(32'h20); tick();
    ovc_in = 0; tick(4); wr(32'h10); tick();
    // R11 all-ones write and foreign address
    wr(32'hFFFF_FFFF); tick();
    wr(32'h0); wr(32'h20); tick();
    wr(32'hFFFF_FFFF, 8'h44); tick();
    addr = 8'h44; tick(2); addr = RA; tick(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule